// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

This block routes eight single-bit data inputs to eight single-bit data outputs. Each output has its own 8:1 selector, so one input may feed any number of outputs at the same time. Each output also has an enable bit. A disabled output drives 0 and drops its enable line. A parameter can make it drive high impedance instead.

The routing map is held in two banks. A host writes one output entry at a time into a staging bank. It places the output number on one address bus, the source input on another, and sets a disable flag, then raises the stage strobe. The live bank keeps steering the data until the host pulses the commit strobe, which copies the whole staging bank across in one clock edge.

A clear control sets both banks at once. With the disable flag low, every output is enabled and fed from input 0. With the flag high, every output is disabled. All three controls act only while chip select is high. If more than one is high, clear wins over commit, and commit wins over stage.

Top module: `xbar_dbuf`

## Requirements
- R1: After `rst_n` is released, every output is enabled (`dout_en` all ones) and forwards input 0.
- R2: `in_sel` and `out_sel` are plain binary numbers with bit 2 as the most significant bit. Staging in_sel=6 to out_sel=1 and then committing makes `dout[1]` follow `din[6]`.
- R3: A stage write changes no data output and no enable until a commit.
- R4: One commit edge moves every staged entry into the live bank together.
- R5: Staging with `off_flag`=1 and then committing makes that output drive 0 with its enable low. Staging it again with `off_flag`=0 and committing enables it.
- R6: A clear with `off_flag`=0 enables every output from input 0 in both banks, so a later commit with no new stage writes keeps that map.
- R7: A clear with `off_flag`=1 disables every output in both banks, so a later commit keeps them all disabled.
- R8: While `chip_sel` is low, `stage_en`, `commit_en` and `clear_en` have no effect on either bank.
- R9: Clear has priority over commit, and commit has priority over stage. A stage write issued on a commit edge is dropped.
- R10: When one input is routed to all outputs, every output follows that input combinationally.
- R11: During a commit, outputs whose entry does not change keep passing their input without interruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the broadcast-from-input-0 map |
| chip_sel | input | 1 | Qualifies stage, commit and clear |
| stage_en | input | 1 | Writes the addressed staging entry on each edge while high |
| commit_en | input | 1 | Copies the staging bank to the live bank on each edge while high |
| clear_en | input | 1 | Sets both banks according to off_flag |
| off_flag | input | 1 | 1 = disable (stage/clear), 0 = enable |
| in_sel | input | 3 | Source input number |
| out_sel | input | 3 | Output entry number |
| din | input | 8 | Data inputs |
| dout | output | 8 | Data outputs |
| dout_en | output | 8 | Per-output enable, high when driving |

## Verification
The live bank drives the outputs through a combinational path. A wrong live entry therefore shows up on `dout`/`dout_en` as soon as `din` is varied in the same cycle. A wrong staging entry stays hidden until the next commit edge, so each scenario ends with a commit and then drives several input patterns. Dropped or leaked control effects, such as chip select being ignored or a stage write on a commit edge, are made visible by a second commit that exposes the staging bank.

// File: rtl/xbar_dbuf.sv
module xbar_dbuf #(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 8,
  parameter bit DRIVE_Z = 1'b0,
  localparam int SW = $clog2(N_IN),
  localparam int OW = $clog2(N_OUT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_sel,
  input  logic             stage_en,
  input  logic             commit_en,
  input  logic             clear_en,
  input  logic             off_flag,
  input  logic [SW-1:0]    in_sel,
  input  logic [OW-1:0]    out_sel,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout,
  output logic [N_OUT-1:0] dout_en
);

  logic [N_OUT-1:0][SW-1:0] stg_sel, act_sel;
  logic [N_OUT-1:0]         stg_en, act_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_sel <= '0;
      act_sel <= '0;
      stg_en  <= '1;
      act_en  <= '1;
    end else if (chip_sel) begin
      if (clear_en) begin
        stg_sel <= '0;
        act_sel <= '0;
        stg_en  <= {N_OUT{!off_flag}};
        act_en  <= {N_OUT{!off_flag}};
      end else if (commit_en) begin
        act_sel <= stg_sel;
        act_en  <= stg_en;
      end else if (stage_en) begin
        stg_sel[out_sel] <= in_sel;
        stg_en[out_sel]  <= !off_flag;
      end
    end
  end

  assign dout_en = act_en;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    if (DRIVE_Z) begin : g_z
      assign dout[o] = act_en[o] ? din[act_sel[o]] : 1'bz;
    end else begin : g_zero
      assign dout[o] = act_en[o] & din[act_sel[o]];
    end
  end

  // R8: nothing moves while chip select is low
  a_r8_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> $stable(stg_sel) && $stable(stg_en) && $stable(act_sel) && $stable(act_en));

  // R3: live bank only changes on commit or clear
  a_r3_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(chip_sel && (commit_en || clear_en)) |=> $stable(act_sel) && $stable(act_en));

  // R4, R9: commit takes the whole staging bank, stage on same edge dropped
  a_r4_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel && commit_en && !clear_en |=>
      act_sel == $past(stg_sel) && act_en == $past(stg_en) && $stable(stg_sel) && $stable(stg_en));

  // R6: clear with flag low broadcasts input 0
  a_r6_clear_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel && clear_en && !off_flag |=> &act_en && &stg_en && act_sel == '0 && stg_sel == '0);

  // R7: clear with flag high disables every output
  a_r7_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel && clear_en && off_flag |=> act_en == '0 && stg_en == '0 && dout_en == '0);

endmodule

// File: tb/sim_xbar_dbuf.sv
module sim_xbar_dbuf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_sel = 0, stage_en = 0, commit_en = 0, clear_en = 0, off_flag = 0;
  logic [2:0] in_sel = '0, out_sel = '0;
  logic [7:0] din = '0, dout, dout_en;
  int n_chk = 0, n_fail = 0;
  int m_stg_sel[8], m_act_sel[8];
  bit m_stg_en[8], m_act_en[8];

  always #4 clk = ~clk;

  xbar_dbuf u0 (.clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .stage_en(stage_en),
    .commit_en(commit_en), .clear_en(clear_en), .off_flag(off_flag), .in_sel(in_sel),
    .out_sel(out_sel), .din(din), .dout(dout), .dout_en(dout_en));

  function automatic logic [7:0] exp_out(logic [7:0] d);
    logic [7:0] r;
    for (int o = 0; o < 8; o++) r[o] = m_act_en[o] & d[m_act_sel[o]];
    return r;
  endfunction

  function automatic logic [7:0] exp_en();
    logic [7:0] r;
    for (int o = 0; o < 8; o++) r[o] = m_act_en[o];
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pats(string tag);
    logic [7:0] pats[4] = '{8'h01, 8'hA5, 8'h5A, 8'hFE};
    for (int p = 0; p < 4; p++) begin
      din = pats[p];
      #1;
      chk(tag, dout, exp_out(din));
    end
    chk(tag, dout_en, exp_en());
  endtask

  task automatic pulse(bit cs, bit st, bit cm, bit cl, bit off, int i, int o);
    @(negedge clk);
    chip_sel = cs; stage_en = st; commit_en = cm; clear_en = cl; off_flag = off;
    in_sel = 3'(i); out_sel = 3'(o);
    @(posedge clk);
    if (cs) begin
      if (cl) begin
        for (int k = 0; k < 8; k++) begin
          m_stg_sel[k] = 0; m_act_sel[k] = 0; m_stg_en[k] = !off; m_act_en[k] = !off;
        end
      end else if (cm) begin
        m_act_sel = m_stg_sel; m_act_en = m_stg_en;
      end else if (st) begin
        m_stg_sel[o] = i; m_stg_en[o] = !off;
      end
    end
    @(negedge clk);
    chip_sel = 0; stage_en = 0; commit_en = 0; clear_en = 0; off_flag = 0;
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) begin m_stg_sel[k] = 0; m_act_sel[k] = 0; m_stg_en[k] = 1; m_act_en[k] = 1; end
    chk_pats("R1 reset map");
    din = 8'h01; #1; chk("R1 input0 fans out", dout, 8'hFF);
  endtask

  task automatic t_route();
    for (int o = 0; o < 8; o++) pulse(1, 1, 0, 0, 0, 7 - o, o);
    chk_pats("R3 staged but not committed");
    pulse(1, 0, 1, 0, 0, 0, 0);
    chk_pats("R4 whole bank committed");
    pulse(1, 1, 0, 0, 0, 6, 1);
    pulse(1, 0, 1, 0, 0, 0, 0);
    din = 8'h40; #1; chk("R2 in6 to out1", {7'b0, dout[1]}, 8'h01);
    din = 8'hBF; #1; chk("R2 in6 to out1 low", {7'b0, dout[1]}, 8'h00);
  endtask

  task automatic t_disable();
    pulse(1, 1, 0, 0, 1, 0, 3);
    pulse(1, 0, 1, 0, 0, 0, 0);
    din = 8'hFF; #1;
    chk("R5 disabled drives 0", {7'b0, dout[3]}, 8'h00);
    chk("R5 disabled enable low", dout_en, 8'hF7);
    pulse(1, 1, 0, 0, 0, 2, 3);
    pulse(1, 0, 1, 0, 0, 0, 0);
    chk_pats("R5 re-enabled");
  endtask

  task automatic t_broadcast();
    for (int o = 0; o < 8; o++) pulse(1, 1, 0, 0, 0, 5, o);
    pulse(1, 0, 1, 0, 0, 0, 0);
    din = 8'h20; #1; chk("R10 broadcast in5 high", dout, 8'hFF);
    din = 8'hDF; #1; chk("R10 broadcast in5 low", dout, 8'h00);
  endtask

  task automatic t_unchanged();
    pulse(1, 1, 0, 0, 0, 1, 0);
    @(negedge clk);
    chip_sel = 1; commit_en = 1; din = 8'h20;
    @(posedge clk);
    #1; chk("R11 steady outputs at commit edge", dout[7:1], 7'h7F);
    din = 8'h00; #1; chk("R11 steady outputs follow", dout[7:1], 7'h00);
    m_act_sel = m_stg_sel; m_act_en = m_stg_en;
    @(negedge clk); chip_sel = 0; commit_en = 0;
    chk_pats("R11 new map");
  endtask

  task automatic t_cs();
    pulse(0, 1, 0, 0, 0, 3, 4);
    pulse(0, 0, 0, 1, 1, 0, 0);
    pulse(0, 0, 1, 0, 0, 0, 0);
    chk_pats("R8 controls ignored without chip select");
    pulse(1, 0, 1, 0, 0, 0, 0);
    chk_pats("R8 staging untouched without chip select");
  endtask

  task automatic t_prio();
    pulse(1, 1, 0, 0, 0, 4, 2);
    pulse(1, 1, 1, 0, 0, 1, 2);
    chk_pats("R9 commit beats stage");
    pulse(1, 0, 1, 0, 0, 0, 0);
    chk_pats("R9 stage on commit edge dropped");
    pulse(1, 1, 0, 0, 0, 7, 6);
    pulse(1, 0, 1, 1, 0, 0, 0);
    chk_pats("R9 clear beats commit");
  endtask

  task automatic t_clear();
    pulse(1, 1, 0, 0, 0, 3, 0);
    pulse(1, 0, 0, 1, 1, 0, 0);
    chk_pats("R7 clear disables");
    pulse(1, 0, 1, 0, 0, 0, 0);
    chk_pats("R7 staging also disabled");
    pulse(1, 1, 0, 0, 0, 3, 0);
    pulse(1, 0, 0, 1, 0, 0, 0);
    chk_pats("R6 clear broadcasts input0");
    pulse(1, 0, 1, 0, 0, 0, 0);
    chk_pats("R6 staging also cleared");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_route();
    t_disable();
    t_broadcast();
    t_unchanged();
    t_cs();
    t_prio();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule